// File: doc/BRIEF.md
# Physical Memory Protection Access Checker

This block decides whether a single memory access may proceed under a table of eight protection entries. Each access has a 34-bit physical byte address, a kind (load, store/atomic or instruction fetch) and the privilege level of the hart that issues it. The block also takes the configuration byte and the 32-bit address word of every entry as flat buses. It compares the access with every entry in parallel and picks the lowest-numbered entry that covers the address. It then applies that entry's permission bits and lock flag and reports allow or deny, together with whether an entry matched and which one.

Each entry covers its region in one of four ways: it is switched off, it covers a range bounded by its own address word and the word of the entry below it, it covers a single aligned word, or it covers an aligned power-of-two block. The size of that block is encoded in the trailing ones of the address word. The decision logic is purely combinational. A parameter adds one output register stage, and that stage is on by default. Storing the entry values, software access to them and raising traps are left to the surrounding logic.

Top module: `pmp_access_check`

## Requirements
- R1: Entry i takes configuration byte `cfg_bus[8i+7:8i]`, with read bit 0, write bit 1, execute bit 2, mode bits 4:3, reserved bits 6:5 and lock bit 7. Its address word `addr_bus[32i+31:32i]` holds physical address bits 33:2. Mode 0 (off) never matches, and the reserved bits have no effect.
- R2: Mode 1 (range) matches when the access word `addr[33:2]` is at least the word of entry i-1 and below the word of entry i. The lower bound is taken even when entry i-1 is off. For entry 0 the lower bound is zero.
- R3: Mode 2 matches only when the access word equals the entry word, which covers four aligned bytes.
- R4: Mode 3 (power-of-two block) treats t trailing ones in the entry word as a 2^(t+3)-byte block. It compares only the word bits above bit t. A word of all ones covers the whole address space.
- R5: When several entries match, the lowest-numbered one decides the result and is reported.
- R6: Access kind is encoded as 0 load, 1 store or atomic, 2 fetch, and privilege as 0 user, 1 supervisor, 3 machine. A matched user or supervisor access is allowed only if the entry's read, write or execute bit for that kind is set. Kind 3 is never granted by permission bits.
- R7: A machine access that matches an unlocked entry is always allowed. When the entry's lock bit is set, its permission bits apply to machine accesses too.
- R8: An access that matches no entry is allowed for machine privilege. For user and supervisor privilege it is allowed only if every entry is off.
- R9: `hit` is 1 exactly when some entry matched and `hit_idx` then gives that entry's number. Without a hit, `hit_idx` is 0.
- R10: With the output register enabled (the default), results appear one clock after the inputs. While `rst` is high, `allow`, `hit` and `hit_idx` are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| req_addr | input | 34 | Physical byte address of the access |
| req_kind | input | 2 | Access kind: 0 load, 1 store/atomic, 2 fetch |
| req_priv | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| cfg_bus | input | 64 | Eight packed entry configuration bytes, entry 0 lowest |
| addr_bus | input | 256 | Eight packed entry address words, entry 0 lowest |
| allow | output | 1 | Access permitted |
| hit | output | 1 | Some entry matched |
| hit_idx | output | 3 | Number of the deciding entry, 0 when no hit |

## Verification
The bench goes after the range boundaries. The last word of a range must match and the entry's own word must not, so an off-by-one comparator would grant or lose a word at the edge of a region. Overlapping entries are set up so that only correct lowest-index priority gives the expected outcome. A design that searched from the top would report the wrong index and the opposite decision. The lock bit is tested on machine accesses, where a design that ignored it would grant locked denials. The all-off table and the all-ones power-of-two word are also tested, because they expose a wrong default policy or a mask that overflows when the trailing-ones run fills the whole word.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } match_mode_e;

  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef struct packed {
    logic        locked;
    logic [1:0]  spare;
    match_mode_e mode;
    logic        px;
    logic        pw;
    logic        pr;
  } entry_cfg_t;

endpackage

// File: rtl/pmp_region_match.sv
module pmp_region_match
  import pmp_chk_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  match_mode_e      mode,
  input  logic [REG_W-1:0] word,
  input  logic [REG_W-1:0] this_reg,
  input  logic [REG_W-1:0] prev_reg,
  output logic             match
);

  logic [REG_W-1:0] napot_mask;
  logic [REG_W-1:0] inc_reg;

  always_comb begin
    inc_reg    = this_reg + {{(REG_W-1){1'b0}}, 1'b1};
    napot_mask = ~(this_reg ^ inc_reg);
  end

  always_comb begin
    unique case (mode)
      MODE_OFF:   match = 1'b0;
      MODE_TOR:   match = (word >= prev_reg) && (word < this_reg);
      MODE_NA4:   match = (word == this_reg);
      MODE_NAPOT: match = ((word & napot_mask) == (this_reg & napot_mask));
      default:    match = 1'b0;
    endcase
  end

  // R1
  off_never_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OFF) |-> !match);

  // R3
  na4_exact_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_NA4 && match) |-> (word == this_reg));

endmodule

// File: rtl/pmp_first_hit.sv
module pmp_first_hit #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     match,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (match[k]) idx = IDX_W'(k);
    end
    hit = |match;
  end

  // R5
  lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> (match[idx] && ((match & ~({N{1'b1}} << idx)) == '0)));

  // R9
  idle_idx_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (idx == '0));

endmodule

// File: rtl/pmp_perm_eval.sv
module pmp_perm_eval
  import pmp_chk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hit,
  input  entry_cfg_t cfg,
  input  logic       any_active,
  input  logic [1:0] priv,
  input  logic [1:0] kind,
  output logic       allow
);

  logic need;

  always_comb begin
    unique case (kind)
      KIND_LOAD:  need = cfg.pr;
      KIND_STORE: need = cfg.pw;
      KIND_FETCH: need = cfg.px;
      default:    need = 1'b0;
    endcase
  end

  always_comb begin
    if (!hit)
      allow = (priv == PRIV_M) || !any_active;
    else if ((priv == PRIV_M) && !cfg.locked)
      allow = 1'b1;
    else
      allow = need;
  end

  // R8
  m_default_chk: assert property (@(posedge clk) disable iff (rst)
    (!hit && priv == PRIV_M) |-> allow);

  // R6
  su_denied_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && priv != PRIV_M && !need) |-> !allow);

  // R7
  m_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && priv == PRIV_M && !cfg.locked) |-> allow);

endmodule

// File: rtl/pmp_access_check.sv
module pmp_access_check
  import pmp_chk_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 34,
  parameter bit OUT_REG     = 1'b1,
  localparam int REG_W      = ADDR_W - 2,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [1:0]                   req_kind,
  input  logic [1:0]                   req_priv,
  input  logic [8*NUM_ENTRIES-1:0]     cfg_bus,
  input  logic [REG_W*NUM_ENTRIES-1:0] addr_bus,
  output logic                         allow,
  output logic                         hit,
  output logic [IDX_W-1:0]             hit_idx
);

  entry_cfg_t             cfgs  [NUM_ENTRIES];
  logic [REG_W-1:0]       regs  [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] match_vec;
  logic [NUM_ENTRIES-1:0] active_vec;
  logic [REG_W-1:0]       word;
  logic                   hit_c;
  logic [IDX_W-1:0]       idx_c;
  logic                   allow_c;
  entry_cfg_t             sel_cfg;

  assign word = req_addr[ADDR_W-1:2];

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    logic [REG_W-1:0] lower;
    assign cfgs[i]       = entry_cfg_t'(cfg_bus[8*i +: 8]);
    assign regs[i]       = addr_bus[REG_W*i +: REG_W];
    assign active_vec[i] = (cfgs[i].mode != MODE_OFF);
    if (i == 0) begin : g_first
      assign lower = '0;
    end else begin : g_rest
      assign lower = addr_bus[REG_W*(i-1) +: REG_W];
    end
    pmp_region_match #(.REG_W(REG_W)) u_match (
      .clk      (clk),
      .rst      (rst),
      .mode     (cfgs[i].mode),
      .word     (word),
      .this_reg (regs[i]),
      .prev_reg (lower),
      .match    (match_vec[i])
    );
  end

  pmp_first_hit #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick (
    .clk   (clk),
    .rst   (rst),
    .match (match_vec),
    .hit   (hit_c),
    .idx   (idx_c)
  );

  assign sel_cfg = cfgs[idx_c];

  pmp_perm_eval u_perm (
    .clk        (clk),
    .rst        (rst),
    .hit        (hit_c),
    .cfg        (sel_cfg),
    .any_active (|active_vec),
    .priv       (req_priv),
    .kind       (req_kind),
    .allow      (allow_c)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        allow   <= 1'b0;
        hit     <= 1'b0;
        hit_idx <= '0;
      end else begin
        allow   <= allow_c;
        hit     <= hit_c;
        hit_idx <= idx_c;
      end
    end

    // R10
    reg_follow_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (allow == $past(allow_c) && hit == $past(hit_c)));

    // R9
    out_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !hit |-> (hit_idx == '0));
  end else begin : g_comb
    assign allow   = allow_c;
    assign hit     = hit_c;
    assign hit_idx = idx_c;
  end

endmodule

// File: tb/tb_pmp_access_check.sv
module tb_pmp_access_check;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [33:0]  req_addr = '0;
  logic [1:0]   req_kind = '0;
  logic [1:0]   req_priv = '0;
  logic [63:0]  cfg_bus  = '0;
  logic [255:0] addr_bus = '0;
  logic         allow;
  logic         hit;
  logic [2:0]   hit_idx;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pmp_access_check dut (
    .clk(clk), .rst(rst), .req_addr(req_addr), .req_kind(req_kind),
    .req_priv(req_priv), .cfg_bus(cfg_bus), .addr_bus(addr_bus),
    .allow(allow), .hit(hit), .hit_idx(hit_idx)
  );

  // {addr, kind, priv, allow, hit, idx}
  localparam int NV = 20;
  localparam logic [42:0] VECS [NV] = '{
    {34'h0000, 2'd0, 2'd0, 1'b1, 1'b1, 3'd0},  // R2 entry0 from zero
    {34'h03FC, 2'd1, 2'd0, 1'b0, 1'b1, 3'd0},  // R6 store needs W
    {34'h0400, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0},  // R2 upper bound excluded, R8
    {34'h03FC, 2'd1, 2'd3, 1'b1, 1'b1, 3'd0},  // R7 M unlocked
    {34'h0802, 2'd1, 2'd1, 1'b1, 1'b1, 3'd1},  // R3 NA4
    {34'h0804, 2'd0, 2'd1, 1'b0, 1'b0, 3'd0},  // R3 next word misses
    {34'h07FC, 2'd0, 2'd3, 1'b1, 1'b0, 3'd0},  // R8 M no match
    {34'h1000, 2'd2, 2'd0, 1'b1, 1'b1, 3'd2},  // R4 NAPOT base
    {34'h107C, 2'd0, 2'd3, 1'b0, 1'b1, 3'd2},  // R7 locked M denied
    {34'h1080, 2'd0, 2'd3, 1'b1, 1'b1, 3'd3},  // R4 NAPOT end, R2 TOR
    {34'h1040, 2'd1, 2'd0, 1'b0, 1'b1, 3'd2},  // R5 overlap lower wins
    {34'h0040, 2'd0, 2'd0, 1'b1, 1'b1, 3'd0},  // R5 entry0 over entry4
    {34'h13FC, 2'd1, 2'd1, 1'b1, 1'b1, 3'd3},  // R2 last word of range
    {34'h1400, 2'd1, 2'd1, 1'b0, 1'b0, 3'd0},  // R2 top excluded
    {34'h1800, 2'd0, 2'd3, 1'b1, 1'b1, 3'd6},  // R1 off entry5 skipped
    {34'h1800, 2'd2, 2'd3, 1'b0, 1'b1, 3'd6},  // R7 locked no X
    {34'h1BFC, 2'd1, 2'd0, 1'b1, 1'b1, 3'd6},  // R6 W granted
    {34'h1FFC, 2'd2, 2'd3, 1'b1, 1'b0, 3'd0},  // R8 M default
    {34'h0FFC, 2'd2, 2'd0, 1'b0, 1'b0, 3'd0},  // R8 U default deny
    {34'h103C, 2'd0, 2'd0, 1'b0, 1'b1, 3'd2}   // R4 X-only read denied
  };

  task automatic set_entry(input int i, input logic [7:0] c, input logic [31:0] w);
    cfg_bus[8*i +: 8]   = c;
    addr_bus[32*i +: 32] = w;
  endtask

  task automatic check(input string tag, input logic ea, input logic eh, input logic [2:0] ei);
    checks++;
    if (allow !== ea || hit !== eh || hit_idx !== ei) begin
      errors++;
      $display("FAIL %s: got allow=%b hit=%b idx=%0d, expected allow=%b hit=%b idx=%0d",
               tag, allow, hit, hit_idx, ea, eh, ei);
    end
  endtask

  task automatic apply(input logic [33:0] a, input logic [1:0] k, input logic [1:0] p);
    @(negedge clk);
    req_addr = a;
    req_kind = k;
    req_priv = p;
    @(negedge clk);
  endtask

  initial begin
    #50000;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    set_entry(0, 8'h09, 32'h0000_0100);
    set_entry(1, 8'h13, 32'h0000_0200);
    set_entry(2, 8'h9C, 32'h0000_040F);
    set_entry(3, 8'h0F, 32'h0000_0500);
    set_entry(4, 8'h90, 32'h0000_0010);
    set_entry(5, 8'h07, 32'h0000_0600);
    set_entry(6, 8'h8B, 32'h0000_0700);
    set_entry(7, 8'h00, 32'h0000_0000);
    req_addr = 34'h0000;
    req_kind = 2'd0;
    req_priv = 2'd3;
    repeat (3) @(negedge clk);
    check("R10 reset holds outputs low", 1'b0, 1'b0, 3'd0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      apply(VECS[v][42:9], VECS[v][8:7], VECS[v][6:5]);
      check($sformatf("vector %0d (R1..R8 table)", v), VECS[v][4], VECS[v][3], VECS[v][2:0]);
    end

    // R10: one-cycle latency
    apply(34'h1800, 2'd0, 2'd3);
    @(negedge clk);
    req_addr = 34'h1FFC;
    req_kind = 2'd2;
    #1;
    check("R10 output unchanged before edge", 1'b1, 1'b1, 3'd6);
    @(negedge clk);
    check("R10 output after edge", 1'b1, 1'b0, 3'd0);

    // R1: reserved bits have no effect
    cfg_bus[8*1 +: 8] = 8'h73;
    apply(34'h0802, 2'd1, 2'd1);
    check("R1 reserved bits ignored", 1'b1, 1'b1, 3'd1);

    // R6: kind 3 never granted
    apply(34'h13FC, 2'd3, 2'd0);
    check("R6 kind 3 denied", 1'b0, 1'b1, 3'd3);

    // R8: all entries off -> user allowed
    cfg_bus = '0;
    apply(34'h0100, 2'd1, 2'd0);
    check("R8 all off allows user", 1'b1, 1'b0, 3'd0);

    // R4: all-ones NAPOT word covers everything
    set_entry(0, 8'h19, 32'hFFFF_FFFF);
    apply(34'h3_FFFF_FFFC, 2'd0, 2'd0);
    check("R4 all-ones NAPOT top address", 1'b1, 1'b1, 3'd0);

    // R2: entry0 TOR with zero word matches nothing
    set_entry(0, 8'h0F, 32'h0000_0000);
    apply(34'h0000, 2'd0, 2'd1);
    check("R2 entry0 empty range", 1'b0, 1'b0, 3'd0);

    // R10: reset clears live outputs
    set_entry(0, 8'h0F, 32'h0000_0100);
    apply(34'h0010, 2'd0, 2'd0);
    check("R9 hit index reported", 1'b1, 1'b1, 3'd0);
    rst = 1'b1;
    @(negedge clk);
    check("R10 reset clears outputs", 1'b0, 1'b0, 3'd0);
    rst = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule